// File: doc/BRIEF.md
# Byte-Write Controller with Toggle-Status Completion Detection

This block is a bus master for a parallel, byte-alterable EEPROM. A host hands it an address and a data byte with a one-cycle start strobe. The block runs one write strobe on the memory bus. It then watches for the end of the memory's internal programming cycle by issuing status reads and looking at one data line, bit 6.

While programming is in progress, bit 6 changes level on every read. The controller therefore keeps only the previous sample of that bit. As soon as two back-to-back reads agree, the write is complete and a one-cycle done pulse goes to the host. The controller never compares against the written byte, and it does not care which level bit 6 starts or ends at. If a programmable number of reads pass without agreement, the block gives up, raises a timeout flag and returns to idle.

The memory data bus is split into input, output and output-enable signals. Chip-enable, output-enable and write-enable are active low.

Top module: `ee_toggle_poller`

## Requirements
- R1: While reset is held, and in idle after reset, mem_ce_n_o, mem_oe_n_o and mem_we_n_o are high, mem_dq_oe_o is low, and busy_o, done_o and timeout_o are low.
- R2: After an accepted start, the controller first spends one setup cycle with the latched address and data driven and chip-enable low. It then holds write-enable low for exactly WR_PULSE_CYC clocks, with chip-enable low and the data bus driven. Data stays driven for one further clock after write-enable rises. Exactly one write-enable pulse occurs per transaction.
- R3: Write-enable is never low while output-enable is low or chip-enable is high.
- R4: Each status read holds chip-enable and output-enable low for exactly ACC_CYC clocks with the data bus not driven. Output-enable returns high for at least one clock between reads.
- R5: Completion is declared after the first pair of consecutive status reads whose bit 6 (index POLL_BIT = 6) values are equal. This holds whatever level bit 6 starts or settles at. With N toggling reads, the number of reads is max(N,1)+1.
- R6: done_o is high for exactly one clock per completed write, and busy_o is low in that clock.
- R7: If MAX_POLLS reads pass without a matching pair, timeout_o rises and the controller returns to idle without a done pulse. timeout_o stays high until the next accepted start clears it.
- R8: A start strobe while busy_o is high is ignored. The memory address does not change, and no second write strobe follows.
- R9: Data bits other than bit 6 have no influence on when completion is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to write a byte |
| addr_i | input | ADDR_W | Target address, latched on accepted start |
| data_i | input | DATA_W | Byte to write, latched on accepted start |
| busy_o | output | 1 | High from accepted start until completion or timeout |
| done_o | output | 1 | One-cycle pulse when the write has completed |
| timeout_o | output | 1 | High after polling gave up, until next start |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_dq_i | input | DATA_W | Memory data bus, read side |
| mem_dq_o | output | DATA_W | Memory data bus, drive side |
| mem_dq_oe_o | output | 1 | High when the controller drives the data bus |
| mem_ce_n_o | output | 1 | Active-low chip enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_we_n_o | output | 1 | Active-low write enable |

## Verification
The memory model flips bit 6 for a chosen number of reads N after each write, starting from a random level, and also churns the other bits on every read. The bench aims at N of 0 and 1, where a design that needed a real toggle before trusting a match would read one time too many. It also covers N equal to MAX_POLLS-1 and MAX_POLLS, which separate the last successful read from the timeout. An off-by-one poll limit would turn one into the other. A start pulse injected during the write strobe would show up as a moved address or a second write-enable pulse if it were accepted. Strobe and read widths are measured on the pins, so a timer loaded one short or one long is caught.

// File: rtl/ee_poll_pkg.sv
`timescale 1ns/1ps
package ee_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RD_GAP,
    ST_RD_ACC
  } poll_state_e;

  // Two successive status samples agree and a previous one exists.
  function automatic logic status_settled(input logic have_prev, input logic prev_b,
                                          input logic cur_b);
    return have_prev && (prev_b == cur_b);
  endfunction

  // The read in progress is the last one allowed.
  function automatic logic is_last_poll(input int unsigned done_reads,
                                        input int unsigned limit);
    return (done_reads + 1) >= limit;
  endfunction

endpackage

// File: rtl/tpoll_cycle_timer.sv
`timescale 1ns/1ps
module tpoll_cycle_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/tpoll_toggle_track.sv
`timescale 1ns/1ps
module tpoll_toggle_track
  import ee_poll_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic match_o
);
  logic prev_q;
  logic have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
    end else if (sample_i) begin
      prev_q <= bit_i;
      have_q <= 1'b1;
    end
  end

  assign match_o = sample_i && status_settled(have_q, prev_q, bit_i);
endmodule

// File: rtl/ee_toggle_poller.sv
`timescale 1ns/1ps
module ee_toggle_poller
  import ee_poll_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int POLL_BIT     = 6,
  parameter int WR_PULSE_CYC = 4,
  parameter int ACC_CYC      = 3,
  parameter int MAX_POLLS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o
);
  localparam int TMR_MAX = (WR_PULSE_CYC > ACC_CYC) ? WR_PULSE_CYC : ACC_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int PC_W    = $clog2(MAX_POLLS + 1);

  poll_state_e       st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [PC_W-1:0]   polls_q;
  logic              done_q, tmo_q;

  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;

  // Named internal events
  logic accept_evt, sample_evt, match_evt, give_up_evt;
  logic unused_dq;

  assign accept_evt  = (st_q == ST_IDLE) && start_i;
  assign sample_evt  = (st_q == ST_RD_ACC) && tmr_zero;
  assign give_up_evt = sample_evt && !match_evt
                       && is_last_poll(int'(polls_q), MAX_POLLS);
  assign unused_dq   = ^mem_dq_i;

  assign tmr_load = (st_q == ST_WR_SETUP) || (st_q == ST_RD_GAP);
  assign tmr_val  = (st_q == ST_WR_SETUP) ? TMR_W'(WR_PULSE_CYC - 1)
                                          : TMR_W'(ACC_CYC - 1);

  tpoll_cycle_timer #(.W(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  tpoll_toggle_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept_evt),
    .sample_i (sample_evt),
    .bit_i    (mem_dq_i[POLL_BIT]),
    .match_o  (match_evt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (start_i) st_d = ST_WR_SETUP;
      ST_WR_SETUP: st_d = ST_WR_PULSE;
      ST_WR_PULSE: if (tmr_zero) st_d = ST_WR_HOLD;
      ST_WR_HOLD:  st_d = ST_RD_GAP;
      ST_RD_GAP:   st_d = ST_RD_ACC;
      ST_RD_ACC: begin
        if (sample_evt) begin
          if (match_evt || give_up_evt) st_d = ST_IDLE;
          else                          st_d = ST_RD_GAP;
        end
      end
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      polls_q <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= match_evt;
      if (accept_evt) begin
        addr_q  <= addr_i;
        data_q  <= data_i;
        polls_q <= '0;
        tmo_q   <= 1'b0;
      end else if (sample_evt) begin
        polls_q <= polls_q + 1'b1;
        if (give_up_evt) tmo_q <= 1'b1;
      end
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = data_q;
  assign mem_dq_oe_o = (st_q == ST_WR_SETUP) || (st_q == ST_WR_PULSE) || (st_q == ST_WR_HOLD);
  assign mem_ce_n_o  = !(mem_dq_oe_o || (st_q == ST_RD_ACC));
  assign mem_oe_n_o  = !(st_q == ST_RD_ACC);
  assign mem_we_n_o  = !(st_q == ST_WR_PULSE);
endmodule

// File: rtl/tpoll_checker.sv
`timescale 1ns/1ps
module tpoll_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              timeout,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr,
  input logic              sample_evt,
  input logic              match_evt
);
  assert_wr_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n));

  assert_we_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);

  assert_read_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && !dq_oe));

  assert_match_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> sample_evt);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_done_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr));
endmodule

bind ee_toggle_poller tpoll_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_o),
  .done       (done_o),
  .timeout    (timeout_o),
  .ce_n       (mem_ce_n_o),
  .oe_n       (mem_oe_n_o),
  .we_n       (mem_we_n_o),
  .dq_oe      (mem_dq_oe_o),
  .addr       (mem_addr_o),
  .sample_evt (sample_evt),
  .match_evt  (match_evt)
);

// File: tb/ee_toggle_poller_tb.sv
`timescale 1ns/1ps
module ee_toggle_poller_tb;
  localparam int AW = 15, DW = 8, WRC = 4, ACC = 3, MAXP = 16;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic busy_o, done_o, timeout_o, dq_oe, ce_n, oe_n, we_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] dq_in, dq_out;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ee_toggle_poller u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .mem_addr_o(mem_addr), .mem_dq_i(dq_in), .mem_dq_o(dq_out), .mem_dq_oe_o(dq_oe),
    .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n)
  );

  // Memory model: bit 6 flips for the first toggle_n reads after a write.
  int  rd_cnt = 0;
  int  toggle_n = 0;
  bit  init_b = 1'b0;

  function automatic logic [DW-1:0] model_word(int k, int n, bit b0);
    logic [DW-1:0] w;
    int m;
    w = DW'(k * 37 + 11);
    m = (k < n) ? k : n;
    w[6] = b0 ^ m[0];
    return w;
  endfunction

  assign dq_in = model_word(rd_cnt, toggle_n, init_b);

  always @(negedge we_n or negedge oe_n) begin
    if (!we_n) rd_cnt = 0;
    else       rd_cnt = rd_cnt + 1;
  end

  // Pin monitors
  int we_pulses = 0, we_run = 0, last_we_len = 0;
  int oe_run = 0, bad_rd_len = 0, viol = 0, done_cyc = 0, done_busy = 0;
  bit prev_we = 1'b1, prev_dqoe = 1'b0;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n && !oe_n) viol++;
      if (!we_n && (ce_n || !dq_oe)) viol++;
      if (!oe_n && (ce_n || dq_oe)) viol++;
      if (prev_we == 1'b0 && we_n && !dq_oe) viol++;
      if (!we_n) begin
        if (prev_we) we_pulses++;
        we_run++;
        cap_addr = mem_addr;
        cap_data = dq_out;
      end else if (we_run != 0) begin
        last_we_len = we_run;
        we_run = 0;
      end
      if (!oe_n) oe_run++;
      else if (oe_run != 0) begin
        if (oe_run != ACC) bad_rd_len++;
        oe_run = 0;
      end
      if (done_o) begin
        done_cyc++;
        if (busy_o) done_busy++;
      end
      prev_we = we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_reads(int n);
    int r;
    r = ((n < 1) ? 1 : n) + 1;
    return (r > MAXP) ? MAXP : r;
  endfunction

  function automatic bit exp_done(int n);
    return (((n < 1) ? 1 : n) + 1) <= MAXP;
  endfunction

  task automatic run_txn(input int n, input bit b0, input bit inject);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int wp0, dc0, bad0, v0, db0;
    bit fin;
    a = AW'($urandom);
    d = DW'($urandom);
    @(negedge clk);
    toggle_n = n;
    init_b = b0;
    wp0 = we_pulses; dc0 = done_cyc; bad0 = bad_rd_len; v0 = viol; db0 = done_busy;
    start_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a; data_i = ~d;
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    chk(timeout_o == 1'b0, "R7", "timeout cleared by start", timeout_o, 0);
    fin = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (inject && c == 3) begin start_i = 1'b1; addr_i = a ^ AW'(5); end
      if (inject && c == 4) start_i = 1'b0;
      if (!busy_o) begin fin = 1'b1; break; end
    end
    start_i = 1'b0;
    chk(fin, "R5", "transaction finished", fin, 1);
    chk(done_o == exp_done(n), "R5", "done at finish", done_o, exp_done(n));
    chk(timeout_o == !exp_done(n), "R7", "timeout at finish", timeout_o, !exp_done(n));
    chk(rd_cnt == exp_reads(n), "R5", "status reads used", rd_cnt, exp_reads(n));
    chk(we_pulses - wp0 == 1, "R2", "write pulses", we_pulses - wp0, 1);
    chk(last_we_len == WRC, "R2", "write pulse width", last_we_len, WRC);
    chk(cap_addr == a, "R8", "write address", cap_addr, a);
    chk(cap_data == d, "R2", "write data", cap_data, d);
    chk(bad_rd_len == bad0, "R4", "bad read widths", bad_rd_len - bad0, 0);
    chk(viol == v0, "R3", "bus rule violations", viol - v0, 0);
    repeat (4) @(negedge clk);
    chk(done_cyc - dc0 == int'(exp_done(n)), "R6", "done cycles", done_cyc - dc0, exp_done(n));
    chk(done_busy == db0, "R6", "done with busy", done_busy - db0, 0);
    chk(busy_o == 1'b0, "R8", "idle after finish", busy_o, 0);
    if (!exp_done(n))
      chk(timeout_o == 1'b1, "R7", "timeout sticky", timeout_o, 1);
    if (inject)
      chk(we_pulses - wp0 == 1, "R8", "no extra write after busy start", we_pulses - wp0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1", "strobes high in reset", {ce_n, oe_n, we_n}, 7);
    chk(!dq_oe && !busy_o && !done_o && !timeout_o, "R1", "idle outputs in reset",
        {dq_oe, busy_o, done_o, timeout_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n && oe_n && we_n && !busy_o, "R1", "idle after reset", {ce_n, oe_n, we_n, busy_o}, 14);
    // Directed corners; R9 is covered because non-status bits churn on every read
    run_txn(0, 1'b0, 1'b0);
    run_txn(0, 1'b1, 1'b0);
    run_txn(1, 1'b1, 1'b0);
    run_txn(2, 1'b0, 1'b1);
    run_txn(MAXP - 1, 1'b1, 1'b0);
    run_txn(MAXP, 1'b0, 1'b0);
    run_txn(3, 1'b1, 1'b0);
    run_txn(MAXP + 5, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++)
      run_txn(int'($urandom_range(0, MAXP + 2)), bit'($urandom), bit'($urandom_range(0, 3) == 0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule